// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block finds the bit rate of a host that opens a serial session by sending the byte 0x00 over and over on an idle-high receive line. With 8 data bits, no parity and one stop bit, each such frame appears on the line as one unbroken low run. That run is nine bit times long: the start bit and eight zero data bits. A high stop bit follows. The detector synchronises the line and times every low run in system clock cycles. It compares each run with the run lengths of the supported host rates, which are 9600, 4800 and 2400 bps. It locks only when two runs in a row fall on the same rate and agree with each other.

On lock the block loads a divisor for a UART that oversamples by 16, computed as the clock frequency over 16 times the matched rate. It raises a locked flag and gives a one-cycle aligned pulse, which a controller uses to send a single 0x00 byte back to the host as confirmation. A run that fits no supported rate raises an error flag, and measuring starts again. Dropping the enable input clears the detector so that a new search can begin.

Top module: `abr_autobaud`

## Requirements
- R1: After reset, locked_o, error_o and aligned_o are 0 and div_o holds CLK_HZ/(16*9600).
- R2: A low run of L cycles on rx_i matches rate B when |L−N|*32 ≤ N, where N = 9*CLK_HZ/B and B is 9600, 4800 or 2400 (BASE_BPS shifted right by 0, 1 or 2). The two-flop synchroniser delays the run but does not change its length.
- R3: When a matching run follows a pending run that matched the same rate, and |L2−L1|*32 ≤ L1, locked_o becomes 1 and div_o becomes CLK_HZ/(16*B).
- R4: aligned_o is high for exactly one cycle per lock. That cycle is the same one in which locked_o first reads 1.
- R5: A run that matches no rate sets error_o and discards any pending run. A later lock clears error_o.
- R6: A low run shorter than CLK_HZ/(4*9600) cycles is a glitch. It is ignored: it does not set error_o and it does not disturb a pending run.
- R7: Once locked, the block ignores further runs, whether they match or not. div_o, locked_o and error_o hold their values and no new aligned pulse appears.
- R8: While en_i is 0, locked_o and error_o read 0 on the next cycle, any pending run is dropped and line activity is ignored. en_i at 0 takes priority over a lock that would complete in the same cycle.
- R9: Two matching runs in a row that differ in rate, or that are more than the R3 margin apart, do not lock. The newer run becomes the pending one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detector enable; 0 clears and holds the search |
| rx_i | input | 1 | Raw serial receive line, idle high |
| div_o | output | DIV_W | Bit-rate divisor for a 16x oversampling UART |
| locked_o | output | 1 | Rate has been found and the divisor is valid |
| error_o | output | 1 | Last run fit no supported rate |
| aligned_o | output | 1 | One-cycle pulse when lock is reached |

## Verification
Two functions can fall in the same cycle: a lock completing at the end of a second agreeing run, and the enable being withdrawn. The bench ends a run at a known negative edge. It then lowers en_i exactly two cycles later, which is the cycle in which the synchronised line rises and the lock decision would be registered. It judges the outcome at the ports: locked_o must stay 0, no aligned pulse may be counted, and two fresh runs after enable returns must lock again with the right divisor.

// File: rtl/abr_pkg.sv
package abr_pkg;

  // Cycles in one low run of a 0x00 frame: start bit plus eight zero bits.
  function automatic int unsigned low_run_cycles(int unsigned clk_hz, int unsigned bps);
    return (9 * clk_hz) / bps;
  endfunction

  // Divisor for a receiver/transmitter that samples 16 times per bit.
  function automatic int unsigned uart_divisor(int unsigned clk_hz, int unsigned bps);
    return clk_hz / (16 * bps);
  endfunction

  // True when a and b differ by no more than ref/32 (about 3.1 percent).
  function automatic logic close_enough(int unsigned a, int unsigned b, int unsigned ref_len);
    int unsigned d;
    d = (a > b) ? (a - b) : (b - a);
    return ((d * 32) <= ref_len);
  endfunction

endpackage

// File: rtl/abr_sync.sv
module abr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/abr_low_meter.sv
module abr_low_meter #(
  parameter int unsigned CNT_W      = 18,
  parameter int unsigned GLITCH_CYC = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_s_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_cnt_q;

  // A run ends when the synchronised line is high again after counting.
  assign meas_cnt_o   = low_cnt_q;
  assign meas_valid_o = en_i && rx_s_i && (32'(low_cnt_q) >= GLITCH_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
    end else if (!en_i || rx_s_i) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != CNT_MAX) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  AST_GLITCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_s_i && en_i && (low_cnt_q != '0) && (32'(low_cnt_q) < GLITCH_CYC)) |-> !meas_valid_o); // R6

  AST_COUNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_s_i |=> (low_cnt_q == '0)); // R2
endmodule

// File: rtl/abr_autobaud.sv
module abr_autobaud #(
  parameter int unsigned CLK_HZ   = 24_000_000,
  parameter int unsigned BASE_BPS = 9600,
  parameter int unsigned NRATES   = 3,
  parameter int unsigned DIV_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_i,
  output logic [DIV_W-1:0] div_o,
  output logic             locked_o,
  output logic             error_o,
  output logic             aligned_o
);
  localparam int unsigned SLOW_BPS   = BASE_BPS >> (NRATES - 1);
  localparam int unsigned CNT_W      = $clog2(2 * abr_pkg::low_run_cycles(CLK_HZ, SLOW_BPS) + 1);
  localparam int unsigned IDX_W      = (NRATES > 1) ? $clog2(NRATES) : 1;
  localparam int unsigned GLITCH_CYC = CLK_HZ / (4 * BASE_BPS);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(abr_pkg::uart_divisor(CLK_HZ, BASE_BPS));

  logic             rx_s;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_cnt;
  logic [NRATES-1:0] rate_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [DIV_W-1:0] div_table [NRATES];

  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [CNT_W-1:0] pend_cnt_q;

  // Named events for checking.
  logic meas_fire, reject_fire, lock_fire, agree;

  abr_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  abr_low_meter #(.CNT_W(CNT_W), .GLITCH_CYC(GLITCH_CYC)) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .rx_s_i       (rx_s),
    .meas_valid_o (meas_valid),
    .meas_cnt_o   (meas_cnt)
  );

  for (genvar i = 0; i < NRATES; i++) begin : g_rate
    localparam int unsigned NOM = abr_pkg::low_run_cycles(CLK_HZ, BASE_BPS >> i);
    assign rate_hit[i]  = abr_pkg::close_enough(32'(meas_cnt), NOM, NOM);
    assign div_table[i] = DIV_W'(abr_pkg::uart_divisor(CLK_HZ, BASE_BPS >> i));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NRATES - 1; i >= 0; i--) begin
      if (rate_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign agree       = abr_pkg::close_enough(32'(meas_cnt), 32'(pend_cnt_q), 32'(pend_cnt_q));
  assign meas_fire   = en_i && meas_valid && !locked_o;
  assign reject_fire = meas_fire && (rate_hit == '0);
  assign lock_fire   = meas_fire && (rate_hit != '0) && pend_q && (pend_idx_q == hit_idx) && agree;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o      <= DIV_RST;
      locked_o   <= 1'b0;
      error_o    <= 1'b0;
      aligned_o  <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_cnt_q <= '0;
    end else if (!en_i) begin
      locked_o  <= 1'b0;
      error_o   <= 1'b0;
      aligned_o <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      aligned_o <= 1'b0;
      if (reject_fire) begin
        error_o <= 1'b1;
        pend_q  <= 1'b0;
      end else if (lock_fire) begin
        locked_o  <= 1'b1;
        aligned_o <= 1'b1;
        error_o   <= 1'b0;
        pend_q    <= 1'b0;
        div_o     <= div_table[hit_idx];
      end else if (meas_fire) begin
        pend_q     <= 1'b1;
        pend_idx_q <= hit_idx;
        pend_cnt_q <= meas_cnt;
      end
    end
  end

  AST_ALIGN_WITH_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |-> (locked_o && !$past(locked_o))); // R4

  AST_ALIGN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |=> !aligned_o); // R4

  AST_LOCK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(meas_valid && en_i)); // R3

  AST_EN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!locked_o && !error_o && !aligned_o)); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(locked_o && error_o)); // R5

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && en_i) |=> $stable(div_o)); // R7

  AST_ONE_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rate_hit)); // R2
endmodule

// File: tb/abr_autobaud_tb.sv
module abr_autobaud_tb_top;
  localparam int unsigned CLK_HZ = 1_843_200;
  localparam int unsigned DIV_W  = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             rx_i = 1'b1;
  logic [DIV_W-1:0] div_o;
  logic             locked_o, error_o, aligned_o;

  int n_checks = 0;
  int n_fail   = 0;
  int n_align  = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;

  abr_autobaud #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) dut_i (
    .clk_i, .rst_ni, .en_i, .rx_i, .div_o, .locked_o, .error_o, .aligned_o
  );

  always @(negedge clk_i) if (aligned_o) n_align++;

  function automatic int bit_cyc(int bps);  return CLK_HZ / bps; endfunction
  function automatic int run_len(int bps);  return bit_cyc(bps) * 9; endfunction
  function automatic int exp_div(int bps);  return bit_cyc(bps) / 16; endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Low run of exactly n cycles, then the line high for hi cycles.
  task automatic frame(int n, int hi);
    @(negedge clk_i) rx_i = 1'b0;
    repeat (n - 1) @(negedge clk_i);
    @(negedge clk_i) rx_i = 1'b1;
    repeat (hi - 1) @(negedge clk_i);
  endtask

  task automatic restart();
    @(negedge clk_i) en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (190_000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int a0;
    int lock_seen;
    a0 = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(locked_o == 0 && error_o == 0 && aligned_o == 0, "R1 flags", {locked_o, error_o, aligned_o}, 0);
    check(div_o == exp_div(9600), "R1 divisor", div_o, exp_div(9600));
    rst_ni = 1'b1; en_i = 1'b1;
    repeat (4) @(negedge clk_i);

    // R3 nominal 9600 lock, R4 single pulse
    lock_seen = n_align;
    frame(run_len(9600), bit_cyc(9600));
    check(locked_o == 0, "R3 no lock after one run", locked_o, 0);
    frame(run_len(9600), bit_cyc(9600));
    check(locked_o == 1, "R3 lock 9600", locked_o, 1);
    check(div_o == exp_div(9600), "R3 divisor 9600", div_o, exp_div(9600));
    check(n_align - lock_seen == 1, "R4 one aligned pulse", n_align - lock_seen, 1);

    // R7 runs after lock are ignored
    frame(run_len(2400), bit_cyc(2400));
    frame(run_len(9600) * 3 / 2, bit_cyc(9600));
    frame(run_len(2400), bit_cyc(2400));
    check(div_o == exp_div(9600) && locked_o == 1, "R7 divisor held", div_o, exp_div(9600));
    check(error_o == 0 && n_align - lock_seen == 1, "R7 no error/pulse", error_o, 0);

    // R2 tolerance boundary: +54 on 1728 matches, +55 does not
    restart();
    frame(run_len(9600) + 55, bit_cyc(9600));
    check(error_o == 1 && locked_o == 0, "R2 outside margin errors", error_o, 1);
    frame(run_len(9600) + 54, bit_cyc(9600));
    frame(run_len(9600) + 54, bit_cyc(9600));
    check(locked_o == 1 && div_o == exp_div(9600), "R2 edge of margin locks", div_o, exp_div(9600));
    check(error_o == 0, "R5 lock clears error", error_o, 0);

    // R5 between-rate run errors and discards pending
    restart();
    frame(run_len(4800), bit_cyc(4800));
    frame(9 * CLK_HZ / 3600, bit_cyc(4800));
    check(error_o == 1, "R5 error on unmatched run", error_o, 1);
    frame(run_len(4800), bit_cyc(4800));
    check(locked_o == 0, "R5 pending discarded", locked_o, 0);
    frame(run_len(4800), bit_cyc(4800));
    check(locked_o == 1 && div_o == exp_div(4800), "R5 relock 4800", div_o, exp_div(4800));

    // R9 rate change and disagreeing runs
    restart();
    frame(run_len(9600), bit_cyc(9600));
    frame(run_len(4800), bit_cyc(4800));
    check(locked_o == 0 && error_o == 0, "R9 rate change no lock", locked_o, 0);
    frame(run_len(4800), bit_cyc(4800));
    check(locked_o == 1 && div_o == exp_div(4800), "R9 newer run pending", div_o, exp_div(4800));
    restart();
    frame(run_len(9600) - 50, bit_cyc(9600));
    frame(run_len(9600) + 50, bit_cyc(9600));
    check(locked_o == 0, "R9 runs too far apart", locked_o, 0);
    frame(run_len(9600) + 50, bit_cyc(9600));
    check(locked_o == 1, "R9 lock on agreeing pair", locked_o, 1);

    // R6 glitches ignored, pending kept
    restart();
    frame(20, 60);
    frame(run_len(9600), bit_cyc(9600));
    frame(bit_cyc(9600) / 4 - 1, 60);
    check(error_o == 0 && locked_o == 0, "R6 glitch no error", error_o, 0);
    frame(run_len(9600), bit_cyc(9600));
    check(locked_o == 1, "R6 pending survives glitch", locked_o, 1);

    // R8 enable low ignores line
    @(negedge clk_i) en_i = 1'b0;
    @(negedge clk_i);
    check(locked_o == 0, "R8 enable clears lock", locked_o, 0);
    frame(run_len(4800), bit_cyc(4800));
    frame(run_len(4800), bit_cyc(4800));
    frame(9 * CLK_HZ / 3600, bit_cyc(4800));
    check(locked_o == 0 && error_o == 0, "R8 line ignored", {locked_o, error_o}, 0);

    // R8 collision: enable drops in the cycle the lock would register
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    frame(run_len(9600), bit_cyc(9600));
    lock_seen = n_align;
    @(negedge clk_i) rx_i = 1'b0;
    repeat (run_len(9600) - 1) @(negedge clk_i);
    @(negedge clk_i) rx_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i) en_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check(locked_o == 0 && n_align == lock_seen, "R8 enable beats lock", locked_o, 0);
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    frame(run_len(9600), bit_cyc(9600));
    frame(run_len(9600), bit_cyc(9600));
    check(locked_o == 1 && n_align - lock_seen == 1, "R8 recovers after collision", locked_o, 1);

    // Random runs within 1 percent of a supported rate
    for (int k = 0; k < 4; k++) begin
      int bps, n1, n2, j1, j2;
      bps = 9600 >> ($urandom % 3);
      j1  = int'($urandom % 21) - 10;
      j2  = int'($urandom % 21) - 10;
      n1  = run_len(bps) + run_len(bps) * j1 / 1000;
      n2  = run_len(bps) + run_len(bps) * j2 / 1000;
      restart();
      lock_seen = n_align;
      frame(n1, bit_cyc(bps) + int'($urandom % 50));
      frame(n2, bit_cyc(bps) + int'($urandom % 50));
      check(locked_o == 1 && div_o == exp_div(bps), "R3 random lock", div_o, exp_div(bps));
      check(n_align - lock_seen == 1, "R4 random pulse", n_align - lock_seen, 1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule